// File: doc/BRIEF.md
# Legacy Segment Limit and Rights Checker

This block checks one memory access against the segment it goes through, the way a processor does outside 64-bit mode. It takes the access address, size and kind together with the segment's selector, base, limit and attribute bits. In the same cycle it returns a single general-protection fault flag, a code saying which check failed, and the linear address that goes on to translation.

Three groups of checks run in parallel. The first catches a null selector. The second compares the access kind with the segment's read and write rights. The third compares the access's start and end offsets with the segment limit. The offset width is 16 or 32 bits and follows from the code segment's default-size bit and a per-access address-size override. An expand-down segment turns the limit test around. A fixed priority picks the reported cause when more than one check fails. The linear address is cut to 32 bits unless the access is in 64-bit submode without an override.

Top module: `seg_guard`

## Requirements
- R1: A selector of zero raises the fault with cause code 1, unless the segment index is one of the exempt system indices 6, 7, 8 and 9.
- R2: For segment indices 0 to 6 only, a write (kind code 1) or a store-probe access to a segment without write right faults, and so does a read (kind code 0) of a segment without read right. An execute access (kind code 2) gets no rights check. A rights fault reports cause code 2.
- R3: The offset is 16 bits wide when `code_dflt32` equals `addr_ovr`, and 32 bits wide when they differ.
- R4: The offset is (address minus base) cut to the offset width. The end offset is offset plus size minus one and is not cut to that width, so a 16-bit access at 0xFFFF of size 2 ends at 0x10000. A size of zero counts as one byte.
- R5: For a normal segment, the access faults with cause code 3 if the offset or the end offset is above the limit.
- R6: For an expand-down segment with index 0 to 6, the access faults with cause code 3 if the offset or the end offset is at or below the limit. For other indices the expand-down bit is ignored.
- R7: When several checks fail, the cause code follows the priority null selector (1), then rights (2), then limit (3). Code 0 means no fault. `gp_fault` is high exactly when the cause code is not 0.
- R8: The linear address equals `vaddr` when `wide_submode` is 1 and `addr_ovr` is 0. Otherwise it is `vaddr[31:0]` with zero extension. Every output follows the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 64 | Access address, segment base already applied |
| acc_size | input | 4 | Access size in bytes (0 counts as 1) |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| store_probe | input | 1 | Read that must also pass the write-right check |
| addr_ovr | input | 1 | Per-access address-size override |
| wide_submode | input | 1 | Access runs in 64-bit submode |
| code_dflt32 | input | 1 | Code segment default-size bit |
| seg_idx | input | 4 | Segment index |
| seg_selector | input | 16 | Selector value of the segment |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit |
| seg_readable | input | 1 | Segment read right |
| seg_writable | input | 1 | Segment write right |
| seg_expdown | input | 1 | Segment grows downward |
| gp_fault | output | 1 | General-protection fault |
| fault_cause | output | 2 | 0 none, 1 null selector, 2 rights, 3 limit |
| lin_addr | output | 64 | Linear address |

## Verification
The block holds no state, so any fault in it shows at the ports in the same cycle as the stimulus. The cases that tell correct from incorrect logic are the edges. The bench drives an offset exactly at the limit and one byte past it, a 16-bit offset whose end carries past 0xFFFF, an expand-down access that touches the limit, and an address below the base that wraps. A wrong offset-width choice turns a legal 16-bit access into a limit fault. A wrong priority shows up as the wrong cause code on an access that breaks several rules at once.

// File: rtl/seg_guard_pkg.sv
// Shared encodings for the segment checker.
// Assumes: kind and cause codes are fixed by the block's requirements.
package seg_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NULL   = 2'd1,
        CAUSE_RIGHTS = 2'd2,
        CAUSE_LIMIT  = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic readable;
        logic writable;
        logic expand_down;
    } seg_attr_t;

endpackage

// File: rtl/seg_rights_unit.sv
// Null-selector and access-rights checks for one access.
// Assumes: indices RIGHTS_LO..RIGHTS_HI are data/code segments; the four
// EXEMPT_* indices may legally hold a zero selector.
module seg_rights_unit
    import seg_guard_pkg::*;
#(
    parameter int IDX_W        = 4,
    parameter int SEL_W        = 16,
    parameter int RIGHTS_LO    = 0,
    parameter int RIGHTS_HI    = 6,
    parameter int EXEMPT_INT_A = 6,
    parameter int EXEMPT_TASK  = 7,
    parameter int EXEMPT_IDT   = 8,
    parameter int EXEMPT_INT_B = 9
) (
    input  logic [IDX_W-1:0] seg_idx,
    input  logic [SEL_W-1:0] selector,
    input  seg_attr_t        attr,
    input  acc_kind_e        kind,
    input  logic             store_probe,
    output logic             null_bad,
    output logic             rights_bad,
    output logic             dir_down
);
    localparam int N_EXEMPT = 4;
    localparam int EXEMPT_LIST [N_EXEMPT] =
        '{EXEMPT_INT_A, EXEMPT_TASK, EXEMPT_IDT, EXEMPT_INT_B};

    logic is_exempt;
    logic in_class;
    logic wants_write;
    logic wants_read;

    // Match the index against the exempt set.
    always_comb begin
        is_exempt = 1'b0;
        for (int i = 0; i < N_EXEMPT; i++) begin
            if (seg_idx == IDX_W'(EXEMPT_LIST[i])) is_exempt = 1'b1;
        end
    end

    // Decide whether the index is a data/code segment.
    always_comb begin
        in_class = 1'b0;
        for (int i = RIGHTS_LO; i <= RIGHTS_HI; i++) begin
            if (seg_idx == IDX_W'(i)) in_class = 1'b1;
        end
    end

    // Classify the access.
    always_comb begin
        wants_write = (kind == ACC_WRITE) || store_probe;
        wants_read  = (kind == ACC_READ);
    end

    // Produce the three verdicts.
    always_comb begin
        null_bad   = (selector == '0) && !is_exempt;
        rights_bad = in_class &&
                     ((wants_write && !attr.writable) ||
                      (wants_read  && !attr.readable));
        dir_down   = in_class && attr.expand_down;
    end

    // Guard: an execute access without a store probe never trips rights.
    always_comb begin
        // R2
        exec_rights_chk: assert (!((kind == ACC_EXEC) && !store_probe && rights_bad))
            else $error("execute access flagged for rights");
    end

endmodule

// File: rtl/seg_offset_unit.sv
// Effective offset and end offset for one access.
// Assumes: addresses wrap modulo 2**OFF_W in the subtraction; size 0 is 1.
module seg_offset_unit #(
    parameter int OFF_W    = 32,
    parameter int NARROW_W = 16,
    parameter int SIZE_W   = 4,
    parameter int END_W    = OFF_W + SIZE_W
) (
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [OFF_W-1:0]  base,
    input  logic              code_dflt32,
    input  logic              addr_ovr,
    input  logic [SIZE_W-1:0] acc_size,
    output logic [OFF_W-1:0]  offset,
    output logic [END_W-1:0]  end_off
);
    logic [OFF_W-1:0]  diff;
    logic              narrow;
    logic [SIZE_W-1:0] eff_size;

    // Pick the width and form the truncated offset.
    always_comb begin
        diff   = addr_lo - base;
        narrow = (code_dflt32 == addr_ovr);
        offset = narrow ? {{(OFF_W-NARROW_W){1'b0}}, diff[NARROW_W-1:0]} : diff;
    end

    // Form the last byte's offset without truncation.
    always_comb begin
        eff_size = (acc_size == '0) ? SIZE_W'(1) : acc_size;
        end_off  = END_W'(offset) + END_W'(eff_size) - END_W'(1);
    end

    // Guard: the end never lies below the start.
    always_comb begin
        // R4
        end_order_chk: assert (end_off >= END_W'(offset))
            else $error("end offset below start offset");
    end

endmodule

// File: rtl/seg_limit_unit.sv
// Limit comparison for normal and expand-down segments.
// Assumes: end_off >= offset, as the offset unit guarantees.
module seg_limit_unit #(
    parameter int OFF_W = 32,
    parameter int END_W = 36,
    parameter int LIM_W = 32
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [END_W-1:0] end_off,
    input  logic [LIM_W-1:0] limit,
    input  logic             dir_down,
    output logic             limit_bad
);
    logic [END_W-1:0] lim_x;
    logic [END_W-1:0] off_x;
    logic             above;
    logic             at_or_below;

    // Compare both ends against the limit.
    always_comb begin
        lim_x       = END_W'(limit);
        off_x       = END_W'(offset);
        above       = (off_x > lim_x) || (end_off > lim_x);
        at_or_below = (off_x <= lim_x) || (end_off <= lim_x);
        limit_bad   = dir_down ? at_or_below : above;
    end

    // Guards on the two directions.
    always_comb begin
        // R5
        up_limit_chk: assert (!(!dir_down && limit_bad) || (end_off > lim_x))
            else $error("normal segment fault with end inside limit");
        // R6
        down_limit_chk: assert (!(dir_down && !limit_bad) || (off_x > lim_x))
            else $error("expand-down pass with start at or below limit");
    end

endmodule

// File: rtl/seg_guard.sv
// Top of the legacy segment checker: combines null, rights and limit
// verdicts into one fault with a prioritised cause and forms the linear
// address. Purely combinational.
// Assumes: vaddr already carries the segment base; ADDR_W > MASK_W.
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MASK_W = 32,
    parameter int OFF_W  = 32,
    parameter int SIZE_W = 4,
    parameter int IDX_W  = 4,
    parameter int SEL_W  = 16
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              store_probe,
    input  logic              addr_ovr,
    input  logic              wide_submode,
    input  logic              code_dflt32,
    input  logic [IDX_W-1:0]  seg_idx,
    input  logic [SEL_W-1:0]  seg_selector,
    input  logic [OFF_W-1:0]  seg_base,
    input  logic [OFF_W-1:0]  seg_limit,
    input  logic              seg_readable,
    input  logic              seg_writable,
    input  logic              seg_expdown,
    output logic              gp_fault,
    output logic [1:0]        fault_cause,
    output logic [ADDR_W-1:0] lin_addr
);
    localparam int END_W = OFF_W + SIZE_W;

    seg_attr_t        attr;
    acc_kind_e        kind;
    logic             null_bad;
    logic             rights_bad;
    logic             dir_down;
    logic             limit_bad;
    logic [OFF_W-1:0] offset;
    logic [END_W-1:0] end_off;
    fault_cause_e     cause;
    logic             cut_addr;

    // Pack the attribute bits and cast the kind.
    always_comb begin
        attr = '{readable: seg_readable, writable: seg_writable,
                 expand_down: seg_expdown};
        kind = acc_kind_e'(acc_kind);
    end

    seg_rights_unit #(
        .IDX_W(IDX_W),
        .SEL_W(SEL_W)
    ) u_rights (
        .seg_idx     (seg_idx),
        .selector    (seg_selector),
        .attr        (attr),
        .kind        (kind),
        .store_probe (store_probe),
        .null_bad    (null_bad),
        .rights_bad  (rights_bad),
        .dir_down    (dir_down)
    );

    seg_offset_unit #(
        .OFF_W (OFF_W),
        .SIZE_W(SIZE_W),
        .END_W (END_W)
    ) u_offset (
        .addr_lo     (vaddr[OFF_W-1:0]),
        .base        (seg_base),
        .code_dflt32 (code_dflt32),
        .addr_ovr    (addr_ovr),
        .acc_size    (acc_size),
        .offset      (offset),
        .end_off     (end_off)
    );

    seg_limit_unit #(
        .OFF_W(OFF_W),
        .END_W(END_W),
        .LIM_W(OFF_W)
    ) u_limit (
        .offset    (offset),
        .end_off   (end_off),
        .limit     (seg_limit),
        .dir_down  (dir_down),
        .limit_bad (limit_bad)
    );

    // Prioritise the cause: null, then rights, then limit.
    always_comb begin
        if (null_bad)        cause = CAUSE_NULL;
        else if (rights_bad) cause = CAUSE_RIGHTS;
        else if (limit_bad)  cause = CAUSE_LIMIT;
        else                 cause = CAUSE_NONE;
        fault_cause = cause;
        gp_fault    = null_bad || rights_bad || limit_bad;
    end

    // Form the linear address, cut to MASK_W bits outside wide addressing.
    always_comb begin
        cut_addr = !wide_submode || addr_ovr;
        lin_addr = cut_addr ? {{(ADDR_W-MASK_W){1'b0}}, vaddr[MASK_W-1:0]} : vaddr;
    end

    // Guards on the combined outputs.
    always_comb begin
        // R7
        fault_code_chk: assert (gp_fault == (fault_cause != 2'd0))
            else $error("fault flag and cause disagree");
        // R7
        null_first_chk: assert (!null_bad || (fault_cause == 2'd1))
            else $error("null selector not reported first");
        // R8
        lin_cut_chk: assert (!cut_addr || (lin_addr[ADDR_W-1:MASK_W] == '0))
            else $error("linear address not cut");
        // R8
        lin_low_chk: assert (lin_addr[MASK_W-1:0] == vaddr[MASK_W-1:0])
            else $error("linear address low bits altered");
    end

endmodule

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad = 0;

    logic [63:0] vaddr = '0;
    logic [3:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        store_probe = 1'b0;
    logic        addr_ovr = 1'b0;
    logic        wide_submode = 1'b0;
    logic        code_dflt32 = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [15:0] seg_selector = '0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic        seg_readable = 1'b0;
    logic        seg_writable = 1'b0;
    logic        seg_expdown = 1'b0;
    logic        gp_fault;
    logic [1:0]  fault_cause;
    logic [63:0] lin_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_guard u_seg_guard (
        .vaddr(vaddr), .acc_size(acc_size), .acc_kind(acc_kind),
        .store_probe(store_probe), .addr_ovr(addr_ovr),
        .wide_submode(wide_submode), .code_dflt32(code_dflt32),
        .seg_idx(seg_idx), .seg_selector(seg_selector), .seg_base(seg_base),
        .seg_limit(seg_limit), .seg_readable(seg_readable),
        .seg_writable(seg_writable), .seg_expdown(seg_expdown),
        .gp_fault(gp_fault), .fault_cause(fault_cause), .lin_addr(lin_addr)
    );

    task automatic check(input string req, input logic ef, input logic [1:0] ec,
                         input logic [63:0] el);
        #1;
        total++;
        if (gp_fault !== ef || fault_cause !== ec || lin_addr !== el) begin
            bad++;
            $display("FAIL %s: got fault=%0b cause=%0d lin=%h, expected fault=%0b cause=%0d lin=%h",
                     req, gp_fault, fault_cause, lin_addr, ef, ec, el);
        end
    endtask

    task automatic defaults();
        vaddr = '0; acc_size = 4'd4; acc_kind = 2'd0; store_probe = 1'b0;
        addr_ovr = 1'b0; wide_submode = 1'b0; code_dflt32 = 1'b1;
        seg_idx = 4'd3; seg_selector = 16'h0010; seg_base = '0;
        seg_limit = 32'hFFFF_FFFF; seg_readable = 1'b1; seg_writable = 1'b1;
        seg_expdown = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 idle zero inputs", 1'b1, 2'd1, 64'h0);
    endtask

    task automatic t_normal_limit();
        defaults();
        seg_base = 32'h1000_0000; seg_limit = 32'h1FF;
        vaddr = 64'h1000_0100; check("R5 inside", 1'b0, 2'd0, 64'h1000_0100);
        vaddr = 64'h1000_01FC; check("R5 end on limit", 1'b0, 2'd0, 64'h1000_01FC);
        vaddr = 64'h1000_01FE; check("R5 end past limit", 1'b1, 2'd3, 64'h1000_01FE);
        vaddr = 64'h1000_0200; acc_size = 4'd1;
        check("R5 start past limit", 1'b1, 2'd3, 64'h1000_0200);
        vaddr = 64'h0FFF_FFF0; acc_size = 4'd1;
        check("R4 below base wraps", 1'b1, 2'd3, 64'h0FFF_FFF0);
    endtask

    task automatic t_width();
        defaults();
        seg_limit = 32'hFFFF; acc_size = 4'd1; vaddr = 64'h0001_2345;
        code_dflt32 = 1'b0; addr_ovr = 1'b0;
        check("R3 16-bit both clear", 1'b0, 2'd0, 64'h0001_2345);
        code_dflt32 = 1'b1; addr_ovr = 1'b1;
        check("R3 16-bit both set", 1'b0, 2'd0, 64'h0001_2345);
        code_dflt32 = 1'b1; addr_ovr = 1'b0;
        check("R3 32-bit default", 1'b1, 2'd3, 64'h0001_2345);
        code_dflt32 = 1'b0; addr_ovr = 1'b1;
        check("R3 32-bit override", 1'b1, 2'd3, 64'h0001_2345);
        code_dflt32 = 1'b0; addr_ovr = 1'b0; vaddr = 64'h0000_FFFF;
        acc_size = 4'd2; check("R4 16-bit end carries", 1'b1, 2'd3, 64'h0000_FFFF);
        acc_size = 4'd1; check("R4 16-bit last byte", 1'b0, 2'd0, 64'h0000_FFFF);
    endtask

    task automatic t_size_zero();
        defaults();
        seg_limit = 32'h1FF; vaddr = 64'h1FF;
        acc_size = 4'd0; check("R4 size zero as one", 1'b0, 2'd0, 64'h1FF);
        acc_size = 4'd2; check("R4 size two past", 1'b1, 2'd3, 64'h1FF);
    endtask

    task automatic t_expand_down();
        defaults();
        seg_idx = 4'd2; seg_expdown = 1'b1; seg_limit = 32'h0FFF;
        vaddr = 64'h1000; check("R6 above limit", 1'b0, 2'd0, 64'h1000);
        vaddr = 64'h0FFF; check("R6 start on limit", 1'b1, 2'd3, 64'h0FFF);
        vaddr = 64'h0FFE; check("R6 straddles limit", 1'b1, 2'd3, 64'h0FFE);
        seg_idx = 4'd8; seg_limit = 32'h100; vaddr = 64'h10;
        check("R6 ignored outside class", 1'b0, 2'd0, 64'h10);
    endtask

    task automatic t_rights();
        defaults();
        seg_writable = 1'b0; acc_kind = 2'd1; vaddr = 64'h40;
        check("R2 write no right", 1'b1, 2'd2, 64'h40);
        acc_kind = 2'd0; store_probe = 1'b1;
        check("R2 store probe", 1'b1, 2'd2, 64'h40);
        store_probe = 1'b0; seg_writable = 1'b1; seg_readable = 1'b0;
        check("R2 read no right", 1'b1, 2'd2, 64'h40);
        acc_kind = 2'd2; check("R2 exec unchecked", 1'b0, 2'd0, 64'h40);
        defaults(); seg_idx = 4'd9; seg_writable = 1'b0; acc_kind = 2'd1;
        check("R2 index outside class", 1'b0, 2'd0, 64'h0);
        seg_idx = 4'd6; check("R2 index 6 in class", 1'b1, 2'd2, 64'h0);
    endtask

    task automatic t_null_and_priority();
        defaults();
        seg_selector = '0; vaddr = 64'h20;
        check("R1 null data segment", 1'b1, 2'd1, 64'h20);
        seg_idx = 4'd7; check("R1 exempt 7", 1'b0, 2'd0, 64'h20);
        seg_idx = 4'd6; check("R1 exempt 6", 1'b0, 2'd0, 64'h20);
        seg_idx = 4'd10; check("R1 index 10 not exempt", 1'b1, 2'd1, 64'h20);
        seg_idx = 4'd3; seg_writable = 1'b0; acc_kind = 2'd1; seg_limit = '0;
        check("R7 null over rights", 1'b1, 2'd1, 64'h20);
        seg_selector = 16'h0008;
        check("R7 rights over limit", 1'b1, 2'd2, 64'h20);
    endtask

    task automatic t_linear();
        defaults();
        wide_submode = 1'b1; seg_base = 32'h2345_0000; vaddr = 64'h1_2345_6789;
        check("R8 wide keeps all bits", 1'b0, 2'd0, 64'h1_2345_6789);
        addr_ovr = 1'b1; check("R8 override cuts", 1'b0, 2'd0, 64'h2345_6789);
        addr_ovr = 1'b0; wide_submode = 1'b0;
        check("R8 legacy cuts", 1'b0, 2'd0, 64'h2345_6789);
    endtask

    initial begin
        #2;
        t_reset_state();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_normal_limit();
        t_width();
        t_size_zero();
        t_expand_down();
        t_rights();
        t_null_and_priority();
        t_linear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got running, expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule